// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Split HI/LO Accumulator

This block carries out a family of sixteen 32x32 multiply operations that share one 64-bit accumulator. The accumulator is held as the low halves of two 64-bit registers, HI and LO. Each operation forms a product from the low 32 bits of two 64-bit sources. The product is either signed or unsigned. The operation can negate the product and can add it to the accumulator that is already held. The new accumulator value is stored back into HI and LO. One 32-bit half of that new value is then returned, sign-extended, as a general-register write value.

The core drives `issue_i` for one cycle with a 5-bit operation field and a signedness select. One clock edge later, the outputs show the updated HI and LO registers, the destination value with its write enable, and a `done_o` pulse. A field value outside the legal set raises `illegal_o` and leaves all state unchanged. Issues may arrive on consecutive cycles, and each issue sees the accumulator written by the issue before it.

Top module: `mac_hilo_unit`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls with no issue, `hi_o`, `lo_o`, `rd_val_o`, `rd_we_o`, `illegal_o` and `done_o` are all zero.
- R2: The accumulator is read as {HI[31:0], LO[31:0]}. A legal issue writes the new accumulator bits 63:32 into HI[31:0] and bits 31:0 into LO[31:0]. The upper 32 bits of each register are filled with copies of its bit 31.
- R3: Only bits 31:0 of `a_i` and `b_i` enter the multiplier. Bits 63:32 of the sources have no effect on any output.
- R4: With `uns_i`=0, both operands are sign-extended to 64 bits before the multiply. With `uns_i`=1, both are zero-extended. The 64-bit product is kept modulo 2^64.
- R5: Bit 2 of `op_i` (weight 4) selects the base of the operation. When it is 1, the base is the held accumulator. When it is 0, the base is zero.
- R6: Bit 1 of `op_i` (weight 2) selects subtraction. When it is 1, the new accumulator is base minus product. When it is 0, it is base plus product. Either way the result wraps modulo 2^64.
- R7: Bit 3 of `op_i` (weight 8) selects which half is returned. When it is 1, the accumulator's upper half is returned. When it is 0, the lower half is returned.
- R8: After a legal issue, `rd_we_o` is 1 for exactly one cycle. During that cycle, `rd_val_o` is the selected half of the new accumulator, sign-extended to 64 bits. This applies to unsigned operations as well.
- R9: `op_i` is legal only when bit 0 is 1 and bit 4 is 0, which gives the codes 0x01, 0x03, 0x05, 0x07, 0x09, 0x0B, 0x0D and 0x0F. Any other code pulses `illegal_o` for one cycle, keeps `rd_we_o` at 0, and leaves HI and LO unchanged.
- R10: All outputs are registered. Results appear after the first rising edge that samples `issue_i`=1, `done_o` pulses in the same cycle, and a back-to-back issue uses the accumulator written by the issue before it.
- R11: In a cycle without `issue_i`, HI and LO hold their values, and `rd_we_o`, `illegal_o` and `done_o` are 0 after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Starts one operation this cycle |
| op_i | input | 5 | Operation field (base, subtract, half select, legality bits) |
| uns_i | input | 1 | 1 = unsigned multiply, 0 = signed |
| a_i | input | 64 | First source operand (bits 31:0 used) |
| b_i | input | 64 | Second source operand (bits 31:0 used) |
| rd_val_o | output | 64 | Destination write value |
| rd_we_o | output | 1 | Destination write enable, one-cycle pulse |
| hi_o | output | 64 | HI register contents |
| lo_o | output | 64 | LO register contents |
| illegal_o | output | 1 | Illegal operation field, one-cycle pulse |
| done_o | output | 1 | Operation completed, one-cycle pulse |

## Verification
The assertions assume that `issue_i`, `op_i` and `uns_i` are steady and defined at each rising edge and that reset is held for at least one edge. Under those assumptions, the stability and pulse checks depend only on port values one cycle apart. The bench changes every input only on falling edges. It leaves `issue_i` low during reset and treats illegal codes as normal issues, so every edge that an assertion samples sees a well-formed request.

// File: rtl/mac_hilo_pkg.sv
package mac_hilo_pkg;

  localparam int OP_W      = 5;
  localparam int OP_VALID  = 0;  // must be 1
  localparam int OP_NEG    = 1;  // subtract the product
  localparam int OP_ACC    = 2;  // base is held accumulator
  localparam int OP_HI     = 3;  // return upper half
  localparam int OP_RSVD   = 4;  // must be 0

  typedef struct packed {
    logic legal;
    logic accum;
    logic negate;
    logic take_hi;
  } mac_ctl_t;

endpackage

// File: rtl/mac_decode.sv
module mac_decode
  import mac_hilo_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output mac_ctl_t        ctl_o
);

  always_comb begin
    ctl_o.legal   = op_i[OP_VALID] & ~op_i[OP_RSVD];
    ctl_o.accum   = op_i[OP_ACC];
    ctl_o.negate  = op_i[OP_NEG];
    ctl_o.take_hi = op_i[OP_HI];
  end

endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int XLEN = 64
) (
  input  logic            uns_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] prod_o
);

  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] src  [2];
  logic [XLEN-1:0] ext  [2];

  assign src[0] = a_i;
  assign src[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_ext
    logic fill;
    assign fill   = src[g][HALF-1] & ~uns_i;
    assign ext[g] = {{HALF{fill}}, src[g][HALF-1:0]};
  end

  // low XLEN bits of the extended product equal the product modulo 2^XLEN
  assign prod_o = ext[0] * ext[1];

endmodule

// File: rtl/mac_accum.sv
module mac_accum
  import mac_hilo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  mac_ctl_t        ctl_i,
  input  logic [XLEN-1:0] acc_i,
  input  logic [XLEN-1:0] prod_i,
  output logic [XLEN-1:0] acc_o
);

  logic [XLEN-1:0] base;

  always_comb begin
    base  = ctl_i.accum ? acc_i : '0;
    acc_o = ctl_i.negate ? (base - prod_i) : (base + prod_i);
  end

endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
  import mac_hilo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_i,
  input  logic [4:0]      op_i,
  input  logic            uns_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] rd_val_o,
  output logic            rd_we_o,
  output logic [XLEN-1:0] hi_o,
  output logic [XLEN-1:0] lo_o,
  output logic            illegal_o,
  output logic            done_o
);

  localparam int HALF = XLEN / 2;

  mac_ctl_t        ctl;
  logic [XLEN-1:0] acc_cur;
  logic [XLEN-1:0] acc_nxt;
  logic [XLEN-1:0] prod;
  logic [XLEN-1:0] hi_nxt;
  logic [XLEN-1:0] lo_nxt;

  logic [XLEN-1:0] hi_q, lo_q, rd_val_q;
  logic            rd_we_q, illegal_q, done_q;

  assign acc_cur = {hi_q[HALF-1:0], lo_q[HALF-1:0]};

  mac_decode u_dec (
    .op_i  (op_i),
    .ctl_o (ctl)
  );

  mac_mult #(.XLEN(XLEN)) u_mul (
    .uns_i  (uns_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod)
  );

  mac_accum #(.XLEN(XLEN)) u_acc (
    .ctl_i  (ctl),
    .acc_i  (acc_cur),
    .prod_i (prod),
    .acc_o  (acc_nxt)
  );

  assign hi_nxt = {{HALF{acc_nxt[XLEN-1]}}, acc_nxt[XLEN-1:HALF]};
  assign lo_nxt = {{HALF{acc_nxt[HALF-1]}}, acc_nxt[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q      <= '0;
      lo_q      <= '0;
      rd_val_q  <= '0;
      rd_we_q   <= 1'b0;
      illegal_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      rd_we_q   <= 1'b0;
      illegal_q <= 1'b0;
      done_q    <= issue_i;
      if (issue_i) begin
        if (ctl.legal) begin
          hi_q     <= hi_nxt;
          lo_q     <= lo_nxt;
          rd_val_q <= ctl.take_hi ? hi_nxt : lo_nxt;
          rd_we_q  <= 1'b1;
        end else begin
          illegal_q <= 1'b1;
        end
      end
    end
  end

  assign rd_val_o  = rd_val_q;
  assign rd_we_o   = rd_we_q;
  assign hi_o      = hi_q;
  assign lo_o      = lo_q;
  assign illegal_o = illegal_q;
  assign done_o    = done_q;

endmodule

// File: rtl/mac_hilo_chk.sv
module mac_hilo_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_i,
  input logic [4:0]      op_i,
  input logic [XLEN-1:0] rd_val_o,
  input logic            rd_we_o,
  input logic [XLEN-1:0] hi_o,
  input logic [XLEN-1:0] lo_o,
  input logic            illegal_o,
  input logic            done_o
);

  localparam int HALF = XLEN / 2;

  // R9: an illegal code leaves HI and LO alone and raises the flag
  a_r9_illegal_no_change: assert property (@(posedge clk) disable iff (rst)
    (issue_i && (!op_i[0] || op_i[4])) |=> (illegal_o && !rd_we_o && $stable(hi_o) && $stable(lo_o)));

  // R11: idle cycles change nothing
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !issue_i |=> (!rd_we_o && !illegal_o && !done_o && $stable(hi_o) && $stable(lo_o)));

  // R10: completion pulse follows every issue
  a_r10_done_follows: assert property (@(posedge clk) disable iff (rst)
    issue_i |=> done_o);

  // R8: write enable and illegal flag are exclusive
  a_r8_we_not_illegal: assert property (@(posedge clk) disable iff (rst)
    !(rd_we_o && illegal_o));

  // R8: the returned value is sign-extended and equals one of the halves
  a_r8_rd_from_half: assert property (@(posedge clk) disable iff (rst)
    rd_we_o |-> ((rd_val_o[XLEN-1:HALF] == {HALF{rd_val_o[HALF-1]}}) &&
                 (rd_val_o == hi_o || rd_val_o == lo_o)));

  // R2: register upper halves mirror bit HALF-1
  a_r2_hi_lo_ext: assert property (@(posedge clk) disable iff (rst)
    (hi_o[XLEN-1:HALF] == {HALF{hi_o[HALF-1]}}) && (lo_o[XLEN-1:HALF] == {HALF{lo_o[HALF-1]}}));

endmodule

bind mac_hilo_unit mac_hilo_chk #(.XLEN(XLEN)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .issue_i   (issue_i),
  .op_i      (op_i),
  .rd_val_o  (rd_val_o),
  .rd_we_o   (rd_we_o),
  .hi_o      (hi_o),
  .lo_o      (lo_o),
  .illegal_o (illegal_o),
  .done_o    (done_o)
);

// File: tb/mac_hilo_unit_tb_top.sv
module mac_hilo_unit_tb_top;

  typedef struct packed {
    logic [4:0]  op;
    logic        uns;
    logic [63:0] a;
    logic [63:0] b;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{5'h01, 1'b0, 64'h0000_0000_0000_0007, 64'h0000_0000_FFFF_FFFD},
    '{5'h01, 1'b1, 64'h0000_0000_0000_0007, 64'h0000_0000_FFFF_FFFD},
    '{5'h09, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000},
    '{5'h09, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0000_8000_0000},
    '{5'h03, 1'b0, 64'h0000_0000_1234_5678, 64'h0000_0000_0000_0010},
    '{5'h03, 1'b1, 64'h0000_0000_1234_5678, 64'h0000_0000_0000_0010},
    '{5'h0B, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    '{5'h0B, 1'b1, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    '{5'h05, 1'b0, 64'h0000_0000_0001_0000, 64'h0000_0000_0001_0000},
    '{5'h05, 1'b1, 64'h0000_0000_FFFF_0000, 64'h0000_0000_0001_0000},
    '{5'h0D, 1'b0, 64'h0000_0000_CAFE_BABE, 64'h0000_0000_0BAD_F00D},
    '{5'h0D, 1'b1, 64'h0000_0000_CAFE_BABE, 64'h0000_0000_0BAD_F00D},
    '{5'h07, 1'b0, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0003},
    '{5'h07, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0003},
    '{5'h0F, 1'b0, 64'h0000_0000_8000_0001, 64'h0000_0000_7FFF_FFFF},
    '{5'h0F, 1'b1, 64'h0000_0000_8000_0001, 64'h0000_0000_7FFF_FFFF},
    '{5'h0D, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    '{5'h0D, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    '{5'h0D, 1'b1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    '{5'h0F, 1'b0, 64'h0000_0000_8000_0000, 64'h0000_0000_7FFF_FFFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_i = 1'b0;
  logic [4:0]  op_i = '0;
  logic        uns_i = 1'b0;
  logic [63:0] a_i = '0, b_i = '0;
  logic [63:0] rd_val_o, hi_o, lo_o;
  logic        rd_we_o, illegal_o, done_o;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [63:0] macc = '0;
  logic [63:0] e_rd = '0;
  logic        e_we = 1'b0, e_ill = 1'b0;

  always #4 clk = ~clk;

  mac_hilo_unit dut_i (
    .clk(clk), .rst(rst), .issue_i(issue_i), .op_i(op_i), .uns_i(uns_i),
    .a_i(a_i), .b_i(b_i), .rd_val_o(rd_val_o), .rd_we_o(rd_we_o),
    .hi_o(hi_o), .lo_o(lo_o), .illegal_o(illegal_o), .done_o(done_o)
  );

  function automatic logic [63:0] sx(input logic [31:0] h);
    return {{32{h[31]}}, h};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model: called at a falling edge, drives the issue and computes expectations
  task automatic drive(input logic [4:0] op, input logic u, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] ea, eb, p, base, nx;
    ea = u ? {32'b0, a[31:0]} : sx(a[31:0]);
    eb = u ? {32'b0, b[31:0]} : sx(b[31:0]);
    p  = ea * eb;
    issue_i = 1'b1; op_i = op; uns_i = u; a_i = a; b_i = b;
    if (op[0] && !op[4]) begin
      base = op[2] ? macc : 64'd0;
      nx   = op[1] ? base - p : base + p;
      macc = nx;
      e_rd = op[3] ? sx(nx[63:32]) : sx(nx[31:0]);
      e_we = 1'b1; e_ill = 1'b0;
    end else begin
      e_we = 1'b0; e_ill = 1'b1;
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " R2 hi"}, hi_o, sx(macc[63:32]));
    chk({tag, " R2 lo"}, lo_o, sx(macc[31:0]));
    chk({tag, " R9 ill"}, {63'd0, illegal_o}, {63'd0, e_ill});
    chk({tag, " R8 we"}, {63'd0, rd_we_o}, {63'd0, e_we});
    chk({tag, " R10 done"}, {63'd0, done_o}, 64'd1);
    if (e_we) chk({tag, " R8 rd"}, rd_val_o, e_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog R10 actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 hi", hi_o, 0); chk("R1 lo", lo_o, 0); chk("R1 rd", rd_val_o, 0);
    chk("R1 flags", {61'd0, rd_we_o, illegal_o, done_o}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {hi_o[31:0], lo_o[31:0]}, 0);

    // table of all variants, back to back (R4 R5 R6 R7 R10)
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].uns, VEC[i].a, VEC[i].b);
      @(negedge clk);
      check_all("R5/R6/R7 vec");
    end
    issue_i = 1'b0;

    // R11: idle keeps state
    @(negedge clk);
    chk("R11 idle hi", hi_o, sx(macc[63:32]));
    chk("R11 idle we", {62'd0, rd_we_o, done_o}, 0);

    // R4: unsigned max squared, HI half: acc = FFFFFFFE_00000001
    drive(5'h09, 1'b1, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    @(negedge clk); issue_i = 1'b0;
    chk("R4 unsigned hi rd", rd_val_o, 64'hFFFF_FFFF_FFFF_FFFE);
    chk("R4 unsigned lo", lo_o, 64'd1);
    // R4: signed (-1)*(-1) = 1, HI half is 0
    drive(5'h09, 1'b0, 64'hFFFF_FFFF, 64'hFFFF_FFFF);
    @(negedge clk); issue_i = 1'b0;
    chk("R4 signed hi rd", rd_val_o, 64'd0);

    // R6: 0 - 1 wraps to all ones
    drive(5'h03, 1'b0, 64'd1, 64'd1);
    @(negedge clk); issue_i = 1'b0;
    chk("R6 wrap rd", rd_val_o, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R6 wrap hi", hi_o, 64'hFFFF_FFFF_FFFF_FFFF);

    // R5: accumulate 2*3 on top of -1 gives 5
    drive(5'h05, 1'b0, 64'd2, 64'd3);
    @(negedge clk); issue_i = 1'b0;
    chk("R5 accumulate rd", rd_val_o, 64'd5);

    // R3: upper source bits ignored
    drive(5'h01, 1'b0, 64'hDEAD_BEEF_0000_0003, 64'hA5A5_A5A5_0000_0004);
    @(negedge clk); issue_i = 1'b0;
    chk("R3 upper ignored", rd_val_o, 64'd12);

    // R9: illegal codes leave state
    drive(5'h00, 1'b0, 64'd9, 64'd9);
    @(negedge clk);
    check_all("R9 code00");
    drive(5'h11, 1'b1, 64'd9, 64'd9);
    @(negedge clk);
    check_all("R9 code11");
    drive(5'h06, 1'b0, 64'd9, 64'd9);
    @(negedge clk); issue_i = 1'b0;
    check_all("R9 code06");
    chk("R9 lo kept", lo_o, 64'd12);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule